// File: doc/BRIEF.md
# Reset Exit Vector Sequencer

This block controls how a processor leaves reset. It keeps track of which of two reset inputs was raised. A power-on reset takes precedence over a manual reset. When reset is released, the block reads the start address from the vector pair that belongs to that reset type. It does this as two 16-bit reads on a simple memory port, and each read waits for a ready/valid handshake. The first word read becomes the upper half of the start address and the second word becomes the lower half.

After the second word arrives, the block spends a fixed internal processing interval and then pulses a fetch-enable for one cycle. That pulse asks the instruction pipeline to prefetch the first instruction at the start address. From the moment any reset is raised until the core reports that this first instruction has completed, every interrupt source is masked, the non-maskable one included. Raising either reset at any time abandons the sequence in progress. Once released, the sequence starts again from the vector read.

Top module: `rstvec_seq`

## Requirements
- R1: While `por_rst` or `man_rst` is high, the outputs are held as follows: `mem_req` = 0, `fetch_en` = 0 and `irq_mask` = 1.
- R2: After a power-on reset, the first vector read is at address 0x000000 and the second is at 0x000002.
- R3: After a manual reset alone, the first vector read is at address 0x000004 and the second is at 0x000006.
- R4: When both resets are high together, the power-on vector pair (0x000000, 0x000002) is used.
- R5: During the fetch-enable pulse, `start_addr` = {first word read, second word read}.
- R6: Once `mem_req` is raised, it stays high with an unchanged `mem_addr` until `mem_ack` is seen, so any number of wait states is tolerated.
- R7: `fetch_en` rises exactly PROC_CYC+1 cycles after the clock edge that accepts the second word. With the default this is 3 cycles. `mem_req` stays low in between.
- R8: `fetch_en` is high for exactly one cycle per sequence.
- R9: `irq_mask` stays 1 through the fetch pulse. It falls in the cycle after `insn_done` is sampled high once the pulse has been issued. An `insn_done` seen earlier has no effect.
- R10: A reset raised in the middle of a sequence aborts it, sets `irq_mask` to 1, and restarts the vector reads after release using the new reset type.
- R11: `mem_ack` while `mem_req` is low has no effect: `mem_req` stays low and the sequence timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, active high, synchronous |
| man_rst | input | 1 | Manual reset, active high, synchronous |
| mem_req | output | 1 | Vector read request (valid) |
| mem_addr | output | AW | Byte address of the vector word |
| mem_ack | input | 1 | Read data ready; the word is taken on the edge where it is high with mem_req |
| mem_rdata | input | DW | Read data word |
| start_addr | output | 2*DW | Assembled start address |
| fetch_en | output | 1 | One-cycle request to prefetch the first instruction at start_addr |
| irq_mask | output | 1 | Masks all interrupts, the non-maskable one included |
| insn_done | input | 1 | First instruction has completed |

## Verification
Three pairs of events can land in the same cycle. A new reset can coincide with a pending vector read or with the wait for the first instruction. An `insn_done` or a stray `mem_ack` can arrive while the block is busy elsewhere in the sequence. The bench provokes these cases in three ways. It raises a reset in the middle of a sequence. It drives random `insn_done` and `mem_ack` levels during the vector wait states and during the processing interval. It also raises both resets together. Each case is judged from the ports: the address of the restarted read, the exact cycle of the fetch pulse, the assembled start address, and whether the mask holds until the done that follows the pulse.

// File: rtl/rstvec_pkg.sv
package rstvec_pkg;
   typedef enum logic [2:0] {
      ST_HOLD, ST_VHI, ST_VLO, ST_PROC, ST_FETCH, ST_WAIT, ST_RUN
   } seq_state_t;

   typedef enum logic {
      RK_POWER, RK_MANUAL
   } rst_kind_t;
endpackage

// File: rtl/rstvec_arb.sv
module rstvec_arb
   import rstvec_pkg::*;
(
   input  logic      clk,
   input  logic      por_rst,
   input  logic      man_rst,
   output logic      rst_any,
   output rst_kind_t kind
);
   assign rst_any = por_rst | man_rst;

   // power-on has priority when both are raised
   always_ff @(posedge clk) begin
      if (por_rst)      kind <= RK_POWER;
      else if (man_rst) kind <= RK_MANUAL;
   end
endmodule

// File: rtl/rstvec_fsm.sv
module rstvec_fsm
   import rstvec_pkg::*;
#(
   parameter int PROC_CYC = 2
) (
   input  logic       clk,
   input  logic       rst_any,
   input  logic       mem_ack,
   input  logic       insn_done,
   output seq_state_t state,
   output logic       hi_we,
   output logic       lo_we
);
   seq_state_t nxt;
   logic       proc_last;

   generate
      if (PROC_CYC == 1) begin : g_proc_one
         assign proc_last = 1'b1;
      end else begin : g_proc_cnt
         localparam int CW = $clog2(PROC_CYC);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (rst_any || state != ST_PROC) cnt <= '0;
            else                             cnt <= cnt + 1'b1;
         end
         assign proc_last = (cnt == CW'(PROC_CYC - 1));
      end
   endgenerate

   always_comb begin
      nxt = state;
      unique case (state)
         ST_HOLD:  nxt = ST_VHI;
         ST_VHI:   if (mem_ack)   nxt = ST_VLO;
         ST_VLO:   if (mem_ack)   nxt = ST_PROC;
         ST_PROC:  if (proc_last) nxt = ST_FETCH;
         ST_FETCH: nxt = ST_WAIT;
         ST_WAIT:  if (insn_done) nxt = ST_RUN;
         ST_RUN:   nxt = ST_RUN;
         default:  nxt = ST_HOLD;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst_any) state <= ST_HOLD;
      else         state <= nxt;
   end

   assign hi_we = (state == ST_VHI) && mem_ack && !rst_any;
   assign lo_we = (state == ST_VLO) && mem_ack && !rst_any;
endmodule

// File: rtl/rstvec_vreg.sv
module rstvec_vreg #(
   parameter int DW = 16
) (
   input  logic            clk,
   input  logic            rst_any,
   input  logic            hi_we,
   input  logic            lo_we,
   input  logic [DW-1:0]   rdata,
   output logic [2*DW-1:0] start_addr
);
   logic [DW-1:0] hi_q, lo_q;

   always_ff @(posedge clk) begin
      if (rst_any) begin
         hi_q <= '0;
         lo_q <= '0;
      end else begin
         if (hi_we) hi_q <= rdata;
         if (lo_we) lo_q <= rdata;
      end
   end

   assign start_addr = {hi_q, lo_q};
endmodule

// File: rtl/rstvec_seq.sv
module rstvec_seq
   import rstvec_pkg::*;
#(
   parameter int AW       = 24,
   parameter int DW       = 16,
   parameter int PROC_CYC = 2,
   parameter int POR_VEC  = 0,
   parameter int MAN_VEC  = 4
) (
   input  logic            clk,
   input  logic            por_rst,
   input  logic            man_rst,
   output logic            mem_req,
   output logic [AW-1:0]   mem_addr,
   input  logic            mem_ack,
   input  logic [DW-1:0]   mem_rdata,
   output logic [2*DW-1:0] start_addr,
   output logic            fetch_en,
   output logic            irq_mask,
   input  logic            insn_done
);
   localparam int WORD_STEP = DW / 8;

   generate
      if (DW % 8 != 0 || DW < 8) begin : g_bad_dw
         $error("rstvec_seq: DW must be a whole number of bytes");
      end
      if (AW < 4) begin : g_bad_aw
         $error("rstvec_seq: AW too small for the vector locations");
      end
      if (PROC_CYC < 1) begin : g_bad_proc
         $error("rstvec_seq: PROC_CYC must be at least 1");
      end
      if (POR_VEC == MAN_VEC) begin : g_bad_vec
         $error("rstvec_seq: the two vector pairs must differ");
      end
   endgenerate

   logic       rst_any;
   rst_kind_t  kind;
   seq_state_t state;
   logic       hi_we, lo_we;
   logic [AW-1:0] base;

   rstvec_arb u_arb (
      .clk(clk), .por_rst(por_rst), .man_rst(man_rst),
      .rst_any(rst_any), .kind(kind)
   );

   rstvec_fsm #(.PROC_CYC(PROC_CYC)) u_fsm (
      .clk(clk), .rst_any(rst_any), .mem_ack(mem_ack),
      .insn_done(insn_done), .state(state), .hi_we(hi_we), .lo_we(lo_we)
   );

   rstvec_vreg #(.DW(DW)) u_vreg (
      .clk(clk), .rst_any(rst_any), .hi_we(hi_we), .lo_we(lo_we),
      .rdata(mem_rdata), .start_addr(start_addr)
   );

   assign base     = (kind == RK_POWER) ? AW'(POR_VEC) : AW'(MAN_VEC);
   assign mem_addr = base + ((state == ST_VLO) ? AW'(WORD_STEP) : '0);
   assign mem_req  = (state == ST_VHI) || (state == ST_VLO);
   assign fetch_en = (state == ST_FETCH);
   assign irq_mask = (state != ST_RUN);
endmodule

// File: rtl/rstvec_chk.sv
module rstvec_chk #(
   parameter int AW       = 24,
   parameter int DW       = 16,
   parameter int POR_VEC  = 0,
   parameter int MAN_VEC  = 4
) (
   input logic            clk,
   input logic            por_rst,
   input logic            man_rst,
   input logic            mem_req,
   input logic [AW-1:0]   mem_addr,
   input logic            mem_ack,
   input logic [2*DW-1:0] start_addr,
   input logic            fetch_en,
   input logic            irq_mask,
   input logic            insn_done
);
   logic any_rst;
   logic armed = 1'b0;
   assign any_rst = por_rst | man_rst;

   always_ff @(posedge clk) armed <= armed | any_rst;

   assert_reset_hold_R1: assert property (@(posedge clk) disable iff (!armed)
      $past(any_rst) |-> (irq_mask && !mem_req && !fetch_en));

   // R2, R3: reads only ever target one of the four vector words
   assert_vec_addr_R2: assert property (@(posedge clk) disable iff (any_rst || !armed)
      mem_req |-> (mem_addr == AW'(POR_VEC) || mem_addr == AW'(POR_VEC + DW/8) ||
                   mem_addr == AW'(MAN_VEC) || mem_addr == AW'(MAN_VEC + DW/8)));

   assert_req_hold_R6: assert property (@(posedge clk) disable iff (any_rst || !armed)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   assert_quiet_before_fetch_R7: assert property (@(posedge clk) disable iff (any_rst || !armed)
      fetch_en |-> (!mem_req && !$past(mem_req)));

   assert_single_pulse_R8: assert property (@(posedge clk) disable iff (any_rst || !armed)
      fetch_en |=> !fetch_en);

   assert_addr_steady_R5: assert property (@(posedge clk) disable iff (any_rst || !armed)
      fetch_en |-> $stable(start_addr));

   assert_mask_at_fetch_R9: assert property (@(posedge clk) disable iff (any_rst || !armed)
      fetch_en |-> irq_mask);

   assert_unmask_needs_done_R9: assert property (@(posedge clk) disable iff (any_rst || !armed)
      $fell(irq_mask) |-> $past(insn_done));
endmodule

bind rstvec_seq rstvec_chk #(.AW(AW), .DW(DW), .POR_VEC(POR_VEC), .MAN_VEC(MAN_VEC)) u_chk (
   .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .mem_req(mem_req),
   .mem_addr(mem_addr), .mem_ack(mem_ack), .start_addr(start_addr),
   .fetch_en(fetch_en), .irq_mask(irq_mask), .insn_done(insn_done)
);

// File: tb/rstvec_seq_test.sv
module rstvec_seq_test;
   localparam int PROC = 2;

   logic        clk = 1'b0;
   logic        por_rst = 1'b0, man_rst = 1'b0;
   logic        mem_req, mem_ack = 1'b0;
   logic [23:0] mem_addr;
   logic [15:0] mem_rdata = '0;
   logic [31:0] start_addr;
   logic        fetch_en, irq_mask;
   logic        insn_done = 1'b0;

   int checks = 0, errors = 0;
   bit finished = 1'b0;

   always #5ns clk = ~clk;

   rstvec_seq uut (
      .clk(clk), .por_rst(por_rst), .man_rst(man_rst),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .start_addr(start_addr), .fetch_en(fetch_en),
      .irq_mask(irq_mask), .insn_done(insn_done)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   function automatic logic [23:0] vec_base(bit p);
      return p ? 24'h000000 : 24'h000004;
   endfunction

   // hold reset for n cycles, then release at a falling edge
   task automatic do_reset(bit p, bit m, int n);
      por_rst = p; man_rst = m; mem_ack = 0; insn_done = 0;
      for (int i = 0; i < n; i++) begin
         tick();
         chk("R1", "irq_mask in reset", 32'(irq_mask), 32'd1);
         chk("R1", "mem_req in reset", 32'(mem_req), 32'd0);
         chk("R1", "fetch_en in reset", 32'(fetch_en), 32'd0);
      end
      por_rst = 0; man_rst = 0;
   endtask

   task automatic serve_word(string tag, logic [23:0] exp_addr, logic [15:0] data, int waits);
      tick();
      mem_ack = 0;
      chk("R6", "mem_req raised", 32'(mem_req), 32'd1);
      chk(tag, "vector address", 32'(mem_addr), 32'(exp_addr));
      for (int i = 0; i < waits; i++) begin
         insn_done = 1'($urandom % 2);
         tick();
         chk("R6", "mem_req held", 32'(mem_req), 32'd1);
         chk("R6", "address held", 32'(mem_addr), 32'(exp_addr));
      end
      mem_ack = 1; mem_rdata = data;
   endtask

   task automatic after_vec(logic [31:0] exp_start, bit stop_at_fetch);
      int n = 0;
      do begin
         tick();
         mem_ack = (n == 0) ? 1'b0 : 1'($urandom % 2);   // R11 stray acks
         insn_done = 1'($urandom % 2);
         n++;
         if (!fetch_en) chk("R11", "no request while processing", 32'(mem_req), 32'd0);
      end while (!fetch_en && n < 8);
      mem_ack = 0; insn_done = 0;
      chk("R7", "fetch pulse delay", 32'(n), 32'(PROC + 1));
      chk("R5", "start address", start_addr, exp_start);
      chk("R9", "mask during fetch", 32'(irq_mask), 32'd1);
      if (stop_at_fetch) return;
      tick();
      chk("R8", "fetch pulse single", 32'(fetch_en), 32'd0);
      chk("R9", "mask after early done", 32'(irq_mask), 32'd1);
      for (int i = 0; i < int'($urandom % 4); i++) begin
         tick();
         chk("R9", "mask while waiting", 32'(irq_mask), 32'd1);
      end
      insn_done = 1;
      tick();
      insn_done = 0;
      chk("R9", "unmask after done", 32'(irq_mask), 32'd0);
      tick();
      chk("R8", "no second pulse", 32'(fetch_en), 32'd0);
      chk("R9", "stays unmasked", 32'(irq_mask), 32'd0);
   endtask

   task automatic trial(bit p, bit m, bit stop_at_fetch);
      string tag;
      logic [15:0] hi, lo;
      logic [23:0] b;
      tag = (p && m) ? "R4" : (p ? "R2" : "R3");
      b = vec_base(p);
      hi = 16'($urandom); lo = 16'($urandom);
      do_reset(p, m, 1 + int'($urandom % 3));
      serve_word(tag, b, hi, int'($urandom % 4));
      serve_word(tag, b + 24'd2, lo, int'($urandom % 4));
      after_vec({hi, lo}, stop_at_fetch);
   endtask

   initial begin
      void'($urandom(32'h1F2E3D4C));
      tick();
      // directed corner cases
      trial(1, 0, 0);
      trial(0, 1, 0);
      trial(1, 1, 0);
      // R10: abort between the two vector reads, switch type
      do_reset(0, 1, 2);
      serve_word("R3", 24'h4, 16'hAAAA, 1);
      tick();
      mem_ack = 0;
      chk("R10", "second read pending", 32'(mem_addr), 32'h6);
      do_reset(1, 0, 2);
      serve_word("R10", 24'h0, 16'h1234, 0);
      serve_word("R10", 24'h2, 16'h5678, 2);
      after_vec(32'h12345678, 0);
      // R10: abort while waiting for the first instruction
      trial(1, 0, 1);
      do_reset(0, 1, 1);
      chk("R10", "mask back on", 32'(irq_mask), 32'd1);
      serve_word("R10", 24'h4, 16'hBEEF, 0);
      serve_word("R10", 24'h6, 16'hCAFE, 0);
      after_vec(32'hBEEFCAFE, 0);
      // constrained random trials
      for (int t = 0; t < 30; t++) begin
         bit p, m;
         p = 1'($urandom % 2);
         m = p ? 1'($urandom % 2) : 1'b1;
         trial(p, m, 0);
      end
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10ns);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule